// File: doc/BRIEF.md
# Linked Command Descriptor Sequencer

This block keeps an accelerator busy through a chain of command blocks stored in system memory. It holds a small file of 32-bit operation registers. Word 0 is the chain-control word and word 1 is the command word. Software fills these registers while the block is idle. The block then starts the current operation. When the arithmetic engine reports that the operation has finished, the block reads the next command block from memory and starts it. That block can carry its own link and enables, so one setup from software can run any number of operations back to back.

Memory is read one 32-bit word per request over a minimal handshake. The block holds `rd_req` and `rd_addr` steady until the memory answers with `rd_valid` or `rd_err`. The block emits single-cycle events: `op_start` for each operation it launches, `fetch_done` when a whole next-command block is loaded, and `fetch_err` when a next-command read fails.

Register layout that the behaviour depends on:
- Chain-control word (register 0): bits 31:2 hold the word address of the next block, so its byte address is always a multiple of 4. Bit 1 enables the next command. Bit 0 enables the current command.
- Command word (register 1): bits 7:0 give the length of the next block in 32-bit words.

Fetched word k lands in register k. In the accelerator's map, register k sits at byte offset 0x20 + 4k.

Top module: `cmdchain_fetch`

## Requirements
- R1: After synchronous reset, all registers read zero and `rd_req`, `op_start`, `fetch_done` and `fetch_err` are low.
- R2: A host write to register `host_idx` takes effect only while the block is idle. A host write while an operation runs or while a block is being fetched is discarded. In an idle cycle that carries a host write, the block takes no other action.
- R3: When idle with register 0 bit 0 set, the block pulses `op_start` for one cycle (one cycle after the decision), clears bit 0, and stays busy until `op_done`.
- R4: On `op_done` with register 0 bit 1 set, the block starts fetching from byte address {reg0[31:2], 2'b00} and clears bit 1. On `op_done` with bit 1 clear, it returns to idle.
- R5: When idle with register 0 bit 0 clear and bit 1 set, the block starts a fetch immediately, without any operation.
- R6: The fetch length is reg1[7:0], taken when the fetch starts. The block reads consecutive word addresses, one request at a time. The request and its address stay stable until `rd_valid` or `rd_err`.
- R7: Fetched word k is written to register k. Words with k >= NREGS are still read but are discarded.
- R8: `fetch_done` pulses for one cycle, one cycle after the last word is accepted. It is never high together with `fetch_err`.
- R9: A fetch length of zero gives `fetch_done` one cycle after the fetch decision, with no memory request.
- R10: `rd_err` during a fetch pulses `fetch_err`, clears register 0 bits 1:0, returns to idle and starts nothing. When `rd_err` and `rd_valid` are high together, the error wins and the word is not written.
- R11: After a completed fetch, the loaded register 0 decides what happens next: bit 0 set starts the operation, bit 0 clear with bit 1 set fetches again, and both clear leaves the block idle.
- R12: `op_done` has no effect while the block is idle or fetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_idx | input | IDX_W | Host register index |
| host_wdata | input | 32 | Host write data |
| op_done | input | 1 | Current operation finished (pulse) |
| op_start | output | 1 | Operation launched (pulse) |
| rd_req | output | 1 | Memory word read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_data | input | 32 | Read data |
| rd_valid | input | 1 | Read data valid |
| rd_err | input | 1 | Read error response |
| fetch_done | output | 1 | Next-command block fully loaded (pulse) |
| fetch_err | output | 1 | Next-command read failed (pulse) |
| regs_o | output | NREGS*32 | Operation register file, register k in bits 32k+31:32k |

## Verification
The bench builds the block with NREGS = 4. A six-word block therefore overruns the register file, which exercises the discard of the surplus words within a short run. The memory model adds one cycle of latency on every odd word, so the bench sees both held requests and back-to-back responses. The register file is small enough that the chain-control word, the command word and the payload words can all be compared on every clock. The chain covers the following cases:
- a self-rewriting link;
- a chained zero-length block;
- an error response raised together with valid.

// File: rtl/cmdchain_pkg.sv
package cmdchain_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 8;

    // Register 0 layout: word address of the next block and two enables.
    typedef struct packed {
        logic [WORD_W-3:0] link;
        logic              nxt_en;
        logic              cur_en;
    } chain_ctrl_t;

    // Register 1 layout: low byte is the next block length in words.
    typedef struct packed {
        logic [WORD_W-LEN_W-1:0] opts;
        logic [LEN_W-1:0]        len;
    } chain_cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_FETCH = 2'd2
    } sq_state_e;

    function automatic logic [WORD_W-1:0] word_to_byte(input logic [WORD_W-3:0] w);
        return {w, 2'b00};
    endfunction

endpackage

// File: rtl/cc_regfile.sv
module cc_regfile
    import cmdchain_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_we,
    input  logic [IDX_W-1:0]        host_idx,
    input  logic [WORD_W-1:0]       host_data,
    input  logic                    fill_we,
    input  logic [IDX_W-1:0]        fill_idx,
    input  logic [WORD_W-1:0]       fill_data,
    input  logic                    clr_cur,
    input  logic                    clr_nxt,
    output logic [NREGS*WORD_W-1:0] regs_o
);

    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        logic [WORD_W-1:0] r;
        logic              hit_host;
        logic              hit_fill;

        assign hit_host = host_we && (32'(host_idx) == k);
        assign hit_fill = fill_we && (32'(fill_idx) == k);
        assign regs_o[k*WORD_W +: WORD_W] = r;

        if (k == 0) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (rst) begin
                    r <= '0;
                end else begin
                    if (hit_host)      r <= host_data;
                    else if (hit_fill) r <= fill_data;
                    if (clr_cur) r[0] <= 1'b0;
                    if (clr_nxt) r[1] <= 1'b0;
                end
            end

            // R10
            enables_cleared_chk: assert property (@(posedge clk) disable iff (rst)
                (clr_cur && clr_nxt && !hit_host && !hit_fill) |=> (r[1:0] == 2'b00));
        end else begin : g_data
            always_ff @(posedge clk) begin
                if (rst)           r <= '0;
                else if (hit_host) r <= host_data;
                else if (hit_fill) r <= fill_data;
            end
        end
    end

endmodule

// File: rtl/cc_sequencer.sv
module cc_sequencer
    import cmdchain_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  chain_ctrl_t       ctrl,
    input  chain_cmd_t        cmd,
    input  logic              host_we,
    input  logic              op_done,
    input  logic              rd_valid,
    input  logic              rd_err,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    output logic              fill_we,
    output logic [LEN_W-1:0]  fill_idx,
    output logic              clr_cur,
    output logic              clr_nxt,
    output logic              op_start,
    output logic              fetch_done,
    output logic              fetch_err,
    output logic              idle
);

    sq_state_e         state;
    logic [WORD_W-3:0] link_q;
    logic [LEN_W-1:0]  left_q;
    logic [LEN_W-1:0]  idx_q;
    logic              op_start_q, done_q, err_q;
    logic              go_run, go_fetch, word_ok, word_bad;

    always_comb begin
        go_run   = 1'b0;
        go_fetch = 1'b0;
        case (state)
            SQ_IDLE: if (!host_we) begin
                if (ctrl.cur_en)      go_run   = 1'b1;
                else if (ctrl.nxt_en) go_fetch = 1'b1;
            end
            SQ_RUN:  if (op_done && ctrl.nxt_en) go_fetch = 1'b1;
            default: ;
        endcase
    end

    assign word_bad = (state == SQ_FETCH) && rd_err;
    assign word_ok  = (state == SQ_FETCH) && rd_valid && !rd_err;
    assign fill_we  = word_ok && (32'(idx_q) < NREGS);
    assign fill_idx = idx_q;
    assign clr_cur  = go_run || word_bad;
    assign clr_nxt  = go_fetch || word_bad;
    assign rd_req   = (state == SQ_FETCH);
    assign rd_addr  = word_to_byte(link_q);
    assign idle     = (state == SQ_IDLE);
    assign op_start   = op_start_q;
    assign fetch_done = done_q;
    assign fetch_err  = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            link_q     <= '0;
            left_q     <= '0;
            idx_q      <= '0;
            op_start_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            op_start_q <= go_run;
            err_q      <= word_bad;
            done_q     <= 1'b0;
            if (go_fetch) begin
                link_q <= ctrl.link;
                left_q <= cmd.len;
                idx_q  <= '0;
                if (cmd.len == '0) begin
                    done_q <= 1'b1;
                    state  <= SQ_IDLE;
                end else begin
                    state  <= SQ_FETCH;
                end
            end else begin
                case (state)
                    SQ_IDLE:  if (go_run) state <= SQ_RUN;
                    SQ_RUN:   if (op_done) state <= SQ_IDLE;
                    SQ_FETCH: begin
                        if (word_bad) begin
                            state <= SQ_IDLE;
                        end else if (word_ok) begin
                            idx_q  <= idx_q + 1'b1;
                            link_q <= link_q + 1'b1;
                            left_q <= left_q - 1'b1;
                            if (left_q == LEN_W'(1)) begin
                                done_q <= 1'b1;
                                state  <= SQ_IDLE;
                            end
                        end
                    end
                    default:  state <= SQ_IDLE;
                endcase
            end
        end
    end

    // R3
    start_consumes_chk: assert property (@(posedge clk) disable iff (rst)
        op_start |-> !ctrl.cur_en);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid && !rd_err) |=> (rd_req && $stable(rd_addr)));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid && !rd_err) |=> (!rd_req || rd_addr == $past(rd_addr) + 32'd4));

    // R10
    err_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_err) |=> (fetch_err && !rd_req && !op_start));

    // R8
    event_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_done && fetch_err));

endmodule

// File: rtl/cmdchain_fetch.sv
module cmdchain_fetch
    import cmdchain_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_we,
    input  logic [IDX_W-1:0]        host_idx,
    input  logic [31:0]             host_wdata,
    input  logic                    op_done,
    output logic                    op_start,
    output logic                    rd_req,
    output logic [31:0]             rd_addr,
    input  logic [31:0]             rd_data,
    input  logic                    rd_valid,
    input  logic                    rd_err,
    output logic                    fetch_done,
    output logic                    fetch_err,
    output logic [NREGS*32-1:0]     regs_o
);

    logic              seq_idle;
    logic              host_ok;
    logic              fill_we;
    logic [LEN_W-1:0]  fill_idx;
    logic              clr_cur, clr_nxt;
    chain_ctrl_t       ctrl;
    chain_cmd_t        cmd;

    assign host_ok = host_we && seq_idle;
    assign ctrl    = chain_ctrl_t'(regs_o[WORD_W-1:0]);
    assign cmd     = chain_cmd_t'(regs_o[2*WORD_W-1:WORD_W]);

    cc_regfile #(.NREGS(NREGS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .host_we   (host_ok),
        .host_idx  (host_idx),
        .host_data (host_wdata),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx[IDX_W-1:0]),
        .fill_data (rd_data),
        .clr_cur   (clr_cur),
        .clr_nxt   (clr_nxt),
        .regs_o    (regs_o)
    );

    cc_sequencer #(.NREGS(NREGS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .cmd        (cmd),
        .host_we    (host_ok),
        .op_done    (op_done),
        .rd_valid   (rd_valid),
        .rd_err     (rd_err),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .fill_we    (fill_we),
        .fill_idx   (fill_idx),
        .clr_cur    (clr_cur),
        .clr_nxt    (clr_nxt),
        .op_start   (op_start),
        .fetch_done (fetch_done),
        .fetch_err  (fetch_err),
        .idle       (seq_idle)
    );

endmodule

// File: tb/cmdchain_fetch_tb.sv
`timescale 1ns/1ps
module cmdchain_fetch_tb;

    localparam int NR = 4;
    localparam int IW = 2;
    localparam int ERR_WORD = 42;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            host_we = 1'b0;
    logic [IW-1:0]   host_idx = '0;
    logic [31:0]     host_wdata = '0;
    logic            op_done = 1'b0;
    logic            op_start;
    logic            rd_req;
    logic [31:0]     rd_addr;
    logic [31:0]     rd_data = '0;
    logic            rd_valid = 1'b0;
    logic            rd_err = 1'b0;
    logic            fetch_done, fetch_err;
    logic [NR*32-1:0] regs_o;

    always #2.5 clk = ~clk;

    cmdchain_fetch #(.NREGS(NR)) u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_idx(host_idx),
        .host_wdata(host_wdata), .op_done(op_done), .op_start(op_start),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_err(rd_err), .fetch_done(fetch_done),
        .fetch_err(fetch_err), .regs_o(regs_o)
    );

    int vectors = 0;
    int fails   = 0;
    int n_start = 0, n_done = 0, n_err = 0, n_reads = 0;
    int wait_cnt = 0;
    logic [31:0] mem [64];

    // Behavioural reference: 0 idle, 1 running, 2 fetching
    int          m_state = 0;
    logic [31:0] m_regs [NR];
    logic [29:0] m_link = '0;
    int          m_left = 0, m_idx = 0;
    bit          exp_start = 0, exp_done = 0, exp_err = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_begin_fetch();
        m_link = m_regs[0][31:2];
        m_left = int'(m_regs[1][7:0]);
        m_idx  = 0;
        m_regs[0][1] = 1'b0;
        if (m_left == 0) begin exp_done = 1; m_state = 0; end
        else m_state = 2;
    endtask

    always @(posedge clk) begin
        exp_start = 0; exp_done = 0; exp_err = 0;
        if (rst) begin
            m_state = 0;
            for (int k = 0; k < NR; k++) m_regs[k] = '0;
        end else begin
            case (m_state)
                0: begin
                    if (host_we) m_regs[host_idx] = host_wdata;
                    else if (m_regs[0][0]) begin
                        m_regs[0][0] = 1'b0; m_state = 1; exp_start = 1;
                    end else if (m_regs[0][1]) m_begin_fetch();
                end
                1: if (op_done) begin
                    if (m_regs[0][1]) m_begin_fetch();
                    else m_state = 0;
                end
                default: begin
                    if (rd_err) begin
                        exp_err = 1; m_regs[0][1:0] = 2'b00; m_state = 0;
                    end else if (rd_valid) begin
                        if (m_idx < NR) m_regs[m_idx] = rd_data;
                        m_idx++; m_link++; m_left--;
                        if (m_left == 0) begin exp_done = 1; m_state = 0; end
                    end
                end
            endcase
        end
    end

    // Per-clock comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            chk("R6 rd_req", {31'd0, rd_req}, {31'd0, m_state == 2});
            if (m_state == 2) chk("R6 rd_addr", rd_addr, {m_link, 2'b00});
            chk("R3 op_start", {31'd0, op_start}, {31'd0, exp_start});
            chk("R8 fetch_done", {31'd0, fetch_done}, {31'd0, exp_done});
            chk("R10 fetch_err", {31'd0, fetch_err}, {31'd0, exp_err});
            for (int k = 0; k < NR; k++) chk("R7 register", regs_o[k*32 +: 32], m_regs[k]);
            n_start += int'(op_start);
            n_done  += int'(fetch_done);
            n_err   += int'(fetch_err);
        end
    end

    // Memory responder: one extra wait cycle on odd words; word 42 errors
    always @(negedge clk) begin
        if (rd_req && !rst) begin
            if (wait_cnt < int'(rd_addr[2])) begin
                wait_cnt++; rd_valid = 1'b0; rd_err = 1'b0;
            end else begin
                wait_cnt = 0;
                rd_valid = 1'b1;
                rd_data  = mem[rd_addr[7:2]];
                rd_err   = (int'(rd_addr[7:2]) == ERR_WORD);
                if (!rd_err) n_reads++;
            end
        end else begin
            rd_valid = 1'b0; rd_err = 1'b0; wait_cnt = 0;
        end
    end

    task automatic host_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_idx = IW'(idx); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic wait_state(input int s);
        int guard = 0;
        while (m_state != s && guard < 2000) begin @(negedge clk); guard++; end
    endtask

    function automatic logic [31:0] reg_at(input int k);
        return regs_o[k*32 +: 32];
    endfunction

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int s0, d0, e0, r0;
        for (int k = 0; k < 64; k++) mem[k] = 32'hBAD0_0000 | k;
        mem[8]  = 32'h0000_0041;  mem[9]  = 32'h0000_0002;  mem[10] = 32'h1234_5678;
        mem[20] = 32'h0000_007A;  mem[21] = 32'h0000_0000;
        mem[22] = 32'hC0DE_0002;  mem[23] = 32'hC0DE_0003;
        mem[24] = 32'hDEAD_0004;  mem[25] = 32'hDEAD_0005;
        mem[40] = 32'h0000_00CB;  mem[41] = 32'h0000_0004;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int k = 0; k < NR; k++) chk("R1 reset register", reg_at(k), 32'd0);
        chk("R1 reset rd_req", {31'd0, rd_req}, 32'd0);
        chk("R1 reset events", {29'd0, op_start, fetch_done, fetch_err}, 32'd0);

        // R3 start current command; R2 busy write dropped; R4 plain finish
        s0 = n_start;
        host_write(0, 32'h0000_0001);
        wait_state(1);
        @(negedge clk);
        chk("R3 start count", n_start - s0, 1);
        chk("R3 enable consumed", reg_at(0), 32'd0);
        host_write(2, 32'hAAAA_5555);
        @(negedge clk);
        chk("R2 busy write ignored", reg_at(2), 32'd0);
        pulse_done();
        repeat (2) @(negedge clk);
        chk("R4 idle after done", {31'd0, rd_req}, 32'd0);
        host_write(2, 32'h0000_0011);
        @(negedge clk);
        chk("R2 idle write taken", reg_at(2), 32'h0000_0011);

        // R4/R6/R7/R11: run, then chain to a block that starts itself
        s0 = n_start; d0 = n_done; r0 = n_reads;
        host_write(1, 32'h0000_0003);
        host_write(0, 32'h0000_0023);
        wait_state(1);
        pulse_done();
        wait_state(1);
        @(negedge clk);
        chk("R6 word reads", n_reads - r0, 3);
        chk("R8 done count", n_done - d0, 1);
        chk("R11 loaded command started", n_start - s0, 2);
        chk("R7 payload word", reg_at(2), 32'h1234_5678);
        chk("R11 loaded enable consumed", reg_at(0), 32'h0000_0040);
        chk("R7 command word", reg_at(1), 32'h0000_0002);
        pulse_done();
        repeat (3) @(negedge clk);
        chk("R4 no further start", n_start - s0, 2);

        // R5 direct fetch, R12 stray done, R7 discard, R9 zero-length chain
        s0 = n_start; d0 = n_done; r0 = n_reads;
        host_write(1, 32'h0000_0006);
        host_write(0, 32'h0000_0052);
        pulse_done();
        repeat (3) @(negedge clk);
        wait_state(0);
        repeat (4) @(negedge clk);
        chk("R6 all six words read", n_reads - r0, 6);
        chk("R9 zero-length done", n_done - d0, 2);
        chk("R12 no start", n_start - s0, 0);
        chk("R5 link kept, enable cleared", reg_at(0), 32'h0000_0078);
        chk("R7 word two", reg_at(2), 32'hC0DE_0002);
        chk("R7 surplus discarded", reg_at(3), 32'hC0DE_0003);
        chk("R9 no request", {31'd0, rd_req}, 32'd0);

        // R10 read error, error wins over valid
        s0 = n_start; d0 = n_done; e0 = n_err; r0 = n_reads;
        host_write(1, 32'h0000_0004);
        host_write(0, 32'h0000_00A2);
        repeat (3) @(negedge clk);
        wait_state(0);
        repeat (3) @(negedge clk);
        chk("R10 error count", n_err - e0, 1);
        chk("R10 enables cleared", reg_at(0), 32'h0000_00C8);
        chk("R10 no start", n_start - s0, 0);
        chk("R10 no done", n_done - d0, 0);
        chk("R10 good reads", n_reads - r0, 2);
        chk("R10 errored word not written", reg_at(2), 32'hC0DE_0002);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule